// File: doc/BRIEF.md
# Up/down wiper position counter

This block holds the tap position of a digitally controlled resistor divider. It is an 8-bit register, and its code picks one of 256 taps. The block decodes the code into one-hot enables for the switch array. Code 0 connects the wiper to the low end of the array and the all-ones code connects it to the high end.

The position has four update sources:
- a reload from data register 0 at reset and on request;
- a parallel transfer from one of the bank-0 data registers;
- a direct write from the serial host;
- single-step moves up or down, which stop at the ends and do not wrap.

When sources collide in one cycle, a fixed priority decides which one takes effect.

The analog tap needs time to settle after it moves. The block models this with a valid flag. The flag drops whenever the position changes and rises again after a parameterised number of clock cycles.

Top module: `wiper_counter`

## Requirements
- R1: While `rstN` is low, `wiperPos` is 0, `tapSel` equals 1 (bit 0 only) and `wiperValid` is low.
- R2: At the first clock edge after `rstN` rises, `wiperPos` loads data register 0. Data register n sits in bits 8n+7:8n of `bank0Regs`, so register 0 is bits 7:0.
- R3: A `recallReq` pulse reloads `wiperPos` from data register 0 at the next edge.
- R4: A `xferReq` pulse loads `wiperPos` at the next edge from the data register whose index is `xferSel`.
- R5: A `wrReq` pulse loads `wrData` into `wiperPos` at the next edge.
- R6: A `stepReq` pulse changes `wiperPos` by exactly one at the next edge. It moves up when `stepUp` is 1 and down when `stepUp` is 0.
- R7: A step up at 8'hFF leaves the position at 8'hFF, and a step down at 8'h00 leaves it at 8'h00.
- R8: When several requests are active in the same cycle, only the highest takes effect. The order from highest to lowest is recall, transfer, write, step.
- R9: `tapSel` always has exactly one bit set, and that bit's index equals `wiperPos`.
- R10: `wiperValid` is low in the cycle after an edge that changes `wiperPos`. It rises exactly SETTLE edges after that edge if no further change occurs.
- R11: A write or transfer that reloads the value already held leaves `wiperValid` high. A recall always restarts the settle window, even when the value is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset (power-up) |
| bank0Regs | input | 32 | Bank-0 data registers, register n at bits 8n+7:8n |
| recallReq | input | 1 | Reload position from register 0 |
| xferReq | input | 1 | Load position from selected data register |
| xferSel | input | 2 | Data register index for transfer |
| wrReq | input | 1 | Direct host write of the position |
| wrData | input | 8 | Value for direct write |
| stepReq | input | 1 | Single-step request |
| stepUp | input | 1 | Step direction, 1 toward high end |
| wiperPos | output | 8 | Current wiper code |
| tapSel | output | 256 | One-hot tap switch enables |
| wiperValid | output | 1 | Tap has settled |

## Verification
The bench targets the array ends first. A counter that wraps would jump from 8'hFF to 0 on a step up, and from 0 to 8'hFF on a step down. A wrong priority order would show the write or step value in place of the recalled or transferred one when all requests are raised together. The bench samples the settle flag one edge before and exactly at the end of the window, so an off-by-one in the settle count shows up. It also checks that a same-value write keeps the flag high while a same-value recall drops it. A decoder with a reversed or shifted index would show a `tapSel` that no longer matches `wiperPos`.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  typedef struct packed {
    logic recall;
    logic xfer;
    logic write;
    logic up;
    logic down;
  } wiperStrobe_t;
endpackage

// File: rtl/wiper_ctrl.sv
module wiper_ctrl
  import wiper_pkg::*;
#(
  parameter int SETTLE = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         recallReq,
  input  logic         xferReq,
  input  logic         wrReq,
  input  logic         stepReq,
  input  logic         stepUp,
  input  logic         posWillChange,
  output wiperStrobe_t strobe,
  output logic         wiperValid
);
  localparam int CNT_W = $clog2(SETTLE + 1);

  logic             bootPending;
  logic [CNT_W-1:0] settleCnt;

  // Fixed priority: recall, transfer, write, step.
  always_comb begin
    strobe        = '0;
    strobe.recall = bootPending | recallReq;
    strobe.xfer   = !strobe.recall & xferReq;
    strobe.write  = !strobe.recall & !xferReq & wrReq;
    strobe.up     = !strobe.recall & !xferReq & !wrReq & stepReq & stepUp;
    strobe.down   = !strobe.recall & !xferReq & !wrReq & stepReq & !stepUp;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bootPending <= 1'b1;
      settleCnt   <= CNT_W'(SETTLE);
    end else begin
      bootPending <= 1'b0;
      if (strobe.recall || posWillChange)
        settleCnt <= CNT_W'(SETTLE);
      else if (settleCnt != '0)
        settleCnt <= settleCnt - 1'b1;
    end
  end

  assign wiperValid = rstN && (settleCnt == '0);

  // R8: at most one update strobe per cycle
  p_single_strobe_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

  // R8: a recall request always wins
  p_recall_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    recallReq |-> (strobe.recall && !strobe.xfer && !strobe.write));

  // R11: valid drops after a recall
  p_recall_restart_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.recall |=> !wiperValid);
endmodule

// File: rtl/wiper_datapath.sv
module wiper_datapath
  import wiper_pkg::*;
#(
  parameter int POS_W  = 8,
  parameter int NUM_DR = 4,
  localparam int SEL_W = $clog2(NUM_DR),
  localparam int TAPS  = 1 << POS_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  wiperStrobe_t            strobe,
  input  logic [NUM_DR*POS_W-1:0] bank0Regs,
  input  logic [SEL_W-1:0]        xferSel,
  input  logic [POS_W-1:0]        wrData,
  output logic [POS_W-1:0]        pos,
  output logic                    posWillChange,
  output logic [TAPS-1:0]         tapSel
);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [POS_W-1:0] drArr [NUM_DR];
  logic [POS_W-1:0] posNext;

  for (genvar d = 0; d < NUM_DR; d++) begin : g_dr
    assign drArr[d] = bank0Regs[d*POS_W +: POS_W];
  end

  always_comb begin
    posNext = pos;
    if (strobe.recall)
      posNext = drArr[0];
    else if (strobe.xfer)
      posNext = drArr[xferSel];
    else if (strobe.write)
      posNext = wrData;
    else if (strobe.up && pos != POS_MAX)
      posNext = pos + 1'b1;
    else if (strobe.down && pos != '0)
      posNext = pos - 1'b1;
  end

  assign posWillChange = (posNext != pos);

  always_ff @(posedge clk) begin
    if (!rstN) pos <= '0;
    else       pos <= posNext;
  end

  // One switch enable per tap; code 0 is the low terminal.
  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    assign tapSel[t] = (pos == POS_W'(t));
  end

  // R7: stepping up at the top holds
  p_hold_top_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.up && pos == POS_MAX) |=> pos == POS_MAX);

  // R7: stepping down at the bottom holds
  p_hold_bottom_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.down && pos == '0) |=> pos == '0);

  // R5: a write lands the host value
  p_write_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.write |=> pos == $past(wrData));

  // R9: exactly one tap switch on
  p_onehot_tap_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(tapSel));
endmodule

// File: rtl/wiper_counter.sv
module wiper_counter
  import wiper_pkg::*;
#(
  parameter int POS_W  = 8,
  parameter int NUM_DR = 4,
  parameter int SETTLE = 8,
  localparam int SEL_W = $clog2(NUM_DR),
  localparam int TAPS  = 1 << POS_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_DR*POS_W-1:0] bank0Regs,
  input  logic                    recallReq,
  input  logic                    xferReq,
  input  logic [SEL_W-1:0]        xferSel,
  input  logic                    wrReq,
  input  logic [POS_W-1:0]        wrData,
  input  logic                    stepReq,
  input  logic                    stepUp,
  output logic [POS_W-1:0]        wiperPos,
  output logic [TAPS-1:0]         tapSel,
  output logic                    wiperValid
);
  wiperStrobe_t strobe;
  logic         posWillChange;

  wiper_ctrl #(.SETTLE(SETTLE)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .recallReq    (recallReq),
    .xferReq      (xferReq),
    .wrReq        (wrReq),
    .stepReq      (stepReq),
    .stepUp       (stepUp),
    .posWillChange(posWillChange),
    .strobe       (strobe),
    .wiperValid   (wiperValid)
  );

  wiper_datapath #(.POS_W(POS_W), .NUM_DR(NUM_DR)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .bank0Regs    (bank0Regs),
    .xferSel      (xferSel),
    .wrData       (wrData),
    .pos          (wiperPos),
    .posWillChange(posWillChange),
    .tapSel       (tapSel)
  );

  // R10: any position change is followed by an unsettled flag
  p_change_unsettles_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wiperPos != $past(wiperPos)) |-> !wiperValid);
endmodule

// File: tb/tb_wiper_counter.sv
module tb_wiper_counter;
  localparam int SETTLE = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] bank0Regs = '0;
  logic        recallReq = 1'b0, xferReq = 1'b0, wrReq = 1'b0, stepReq = 1'b0, stepUp = 1'b0;
  logic [1:0]  xferSel = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  wiperPos;
  logic [255:0] tapSel;
  logic        wiperValid;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wiper_counter #(.SETTLE(SETTLE)) dut (
    .clk(clk), .rstN(rstN), .bank0Regs(bank0Regs), .recallReq(recallReq),
    .xferReq(xferReq), .xferSel(xferSel), .wrReq(wrReq), .wrData(wrData),
    .stepReq(stepReq), .stepUp(stepUp), .wiperPos(wiperPos), .tapSel(tapSel),
    .wiperValid(wiperValid)
  );

  task automatic chkPos(input logic [7:0] exp, input string tag);
    checks++;
    if (wiperPos !== exp) begin
      failures++;
      $display("FAIL %s wiperPos actual=%h expected=%h", tag, wiperPos, exp);
    end
    checks++;
    if (tapSel !== (256'b1 << exp)) begin
      failures++;
      $display("FAIL R9 (%s) tapSel actual=%h expected bit %0d", tag, tapSel, exp);
    end
  endtask

  task automatic chkValid(input logic exp, input string tag);
    checks++;
    if (wiperValid !== exp) begin
      failures++;
      $display("FAIL %s wiperValid actual=%b expected=%b", tag, wiperValid, exp);
    end
  endtask

  task automatic clearReqs();
    recallReq = 0; xferReq = 0; wrReq = 0; stepReq = 0;
  endtask

  task automatic settle();
    repeat (SETTLE + 1) @(negedge clk);
  endtask

  task automatic doWrite(input logic [7:0] v);
    wrReq = 1; wrData = v;
    @(negedge clk);
    clearReqs();
  endtask

  task automatic doStep(input logic up);
    stepReq = 1; stepUp = up;
    @(negedge clk);
    clearReqs();
  endtask

  task automatic testReset();
    bank0Regs = 32'h44_33_22_5A;
    rstN = 0;
    repeat (3) @(negedge clk);
    chkPos(8'h00, "R1");
    chkValid(1'b0, "R1");
    rstN = 1;
    @(negedge clk);
    chkPos(8'h5A, "R2");
    chkValid(1'b0, "R2");
    repeat (SETTLE - 1) @(negedge clk);
    chkValid(1'b0, "R10 boot");
    @(negedge clk);
    chkValid(1'b1, "R10 boot");
  endtask

  task automatic testRecall();
    doWrite(8'h10);
    bank0Regs[7:0] = 8'hC3;
    recallReq = 1;
    @(negedge clk);
    clearReqs();
    chkPos(8'hC3, "R3");
    settle();
  endtask

  task automatic testXfer();
    for (int s = 0; s < 4; s++) begin
      xferReq = 1; xferSel = 2'(s);
      @(negedge clk);
      clearReqs();
      chkPos(bank0Regs[s*8 +: 8], "R4");
    end
    settle();
  endtask

  task automatic testWriteAndValid();
    doWrite(8'h81);
    chkPos(8'h81, "R5");
    chkValid(1'b0, "R10");
    repeat (SETTLE - 1) @(negedge clk);
    chkValid(1'b0, "R10");
    @(negedge clk);
    chkValid(1'b1, "R10");
    doWrite(8'h81);
    chkValid(1'b1, "R11 same write");
    xferSel = 2'd1; bank0Regs[15:8] = 8'h81; xferReq = 1;
    @(negedge clk);
    clearReqs();
    chkValid(1'b1, "R11 same xfer");
    bank0Regs[7:0] = 8'h81; recallReq = 1;
    @(negedge clk);
    clearReqs();
    chkPos(8'h81, "R11");
    chkValid(1'b0, "R11 recall restart");
    settle();
  endtask

  task automatic testStep();
    doWrite(8'h7F);
    doStep(1'b1);
    chkPos(8'h80, "R6 up");
    doStep(1'b0);
    doStep(1'b0);
    chkPos(8'h7E, "R6 down");
    settle();
  endtask

  task automatic testSaturate();
    doWrite(8'hFE);
    doStep(1'b1);
    chkPos(8'hFF, "R7 top");
    doStep(1'b1);
    chkPos(8'hFF, "R7 top hold");
    doWrite(8'h01);
    doStep(1'b0);
    chkPos(8'h00, "R7 bottom");
    doStep(1'b0);
    chkPos(8'h00, "R7 bottom hold");
    settle();
  endtask

  task automatic testPriority();
    bank0Regs = 32'hD4_C3_B2_A1;
    doWrite(8'h50);
    recallReq = 1; xferReq = 1; xferSel = 2'd2; wrReq = 1; wrData = 8'h11;
    stepReq = 1; stepUp = 1;
    @(negedge clk);
    clearReqs();
    chkPos(8'hA1, "R8 recall first");
    xferReq = 1; xferSel = 2'd3; wrReq = 1; wrData = 8'h11; stepReq = 1;
    @(negedge clk);
    clearReqs();
    chkPos(8'hD4, "R8 xfer over write");
    wrReq = 1; wrData = 8'h22; stepReq = 1; stepUp = 1;
    @(negedge clk);
    clearReqs();
    chkPos(8'h22, "R8 write over step");
    settle();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    testReset();
    testRecall();
    testXfer();
    testWriteAndValid();
    testStep();
    testSaturate();
    testPriority();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule